// File: doc/BRIEF.md
# Microstep Excitation Sequence Generator

This block produces the per-winding control bits for a two-winding bipolar stepper driver that sets its current with a two-bit level select. Each winding gets a direction bit and a two-bit current code. The code sets the amplitude to full, two-thirds, one-third or off. A step pulse moves an internal state index one position through an excitation table, forward or backward as the direction input says. Each table entry gives the current code and the direction bit for both windings.

A mode input picks one of two tables. One is an 8-state half-step table (45 degree electrical steps). The other is a 16-state quarter-step table (22.5 degree steps) that smooths the torque ripple. When the mode changes, the index is moved to the entry with the same electrical angle, so the rotor does not jump. The driver enables stay on for the whole sequence and are not outputs of this block. The analog reference and current chopping are handled elsewhere.

Top module: `stepSeqGen`

## Requirements
- R1: While reset (rstN low) is asserted, and after it, the index is 0. winding A then shows full current with direction 0, and winding B shows off with direction 0.
- R2: Current code bit 1 is the high select bit and bit 0 is the low select bit. 2'b00 means full, 2'b01 two-thirds, 2'b10 one-third and 2'b11 off.
- R3: In half-step mode (quarterMode=0), the codes for states 0..7 are: A = 00,01,11,01,00,01,11,01 and B = 11,01,00,01,11,01,00,01. Direction bits: A=0 in states 0,1,7 and A=1 in 3,4,5. B=0 in 1,2,3 and B=1 in 5,6,7.
- R4: In quarter-step mode (quarterMode=1), the codes for states 0..15 are: A = 00,00,01,10,11,10,01,00 (repeated) and B = 11,10,01,00,00,00,01,10 (repeated). Direction bits: A=0 in 0..3 and 13..15, A=1 in 5..11. B=0 in 1..7, B=1 in 9..15.
- R5: In any state where a winding's code is 11 (off), its direction output keeps the value it had in the previous cycle.
- R6: A rising step edge is a clock edge that samples stepIn=1 after it sampled stepIn=0. Each such edge moves the index by exactly one state, and the new outputs appear right after that edge. Holding stepIn high moves nothing further.
- R7: dirIn=1 increments the index and dirIn=0 decrements it, modulo the current table length. In half-step mode, 7 goes up to 0 and 0 goes down to 7. In quarter-step mode, 15 goes up to 0 and 0 goes down to 15.
- R8: A change of quarterMode seen at a clock edge remaps the index: half-step k becomes quarter-step 2k, and quarter-step k becomes half-step floor(k/2). A rising step edge at the same clock edge is applied after the remap, in the new mode.
- R9: A step input held high while reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepIn | input | 1 | Step request, acted on at its rising edge |
| dirIn | input | 1 | 1 = forward (increment), 0 = reverse |
| quarterMode | input | 1 | 0 = half-step table, 1 = quarter-step table |
| phaseA | output | 1 | Winding A direction bit |
| curSelA | output | 2 | Winding A current code |
| phaseB | output | 1 | Winding B direction bit |
| curSelB | output | 2 | Winding B current code |

## Verification
Every output is decoded from registered state only. A step edge or a mode change sampled at a clock edge therefore shows at the outputs within that same clock period, one register after the input. The bench changes inputs on the falling edge and updates a table-driven reference model on each rising edge. It compares all four outputs on the next falling edge, so each result is checked in the period it is due, and again on every later clock. The stimulus includes wraps in both directions in both modes, a held step, mode switches at odd and even indices, and a step that coincides with a mode change.

// File: rtl/stepSeqPkg.sv
package stepSeqPkg;
  localparam int IDX_W       = 4;              // quarter-step index width
  localparam int QUARTER_LEN = 1 << IDX_W;     // 16 states
  localparam int HALF_LEN    = QUARTER_LEN / 2; // 8 states
  localparam int CODE_W      = 2;              // current select width
  localparam int NUM_WIND    = 2;
  localparam int QUAD        = QUARTER_LEN / 4; // 90 degrees in quarter steps

  typedef struct packed {
    logic advance;     // one state move this clock
    logic up;          // increment when set
    logic remap;       // table change this clock
    logic nextQuarter; // table in use after this clock
    logic curQuarter;  // table the index currently belongs to
  } seqStrobe_t;
endpackage

// File: rtl/stepSeqControl.sv
module stepSeqControl
  import stepSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic       quarterMode,
  output seqStrobe_t strb
);
  logic stepQ;
  logic modeQ;

  // stepQ resets high so a step held through reset is not an edge (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= 1'b1;
      modeQ <= 1'b0;
    end else begin
      stepQ <= stepIn;
      modeQ <= quarterMode;
    end
  end

  always_comb begin
    strb.advance     = stepIn & ~stepQ;
    strb.up          = dirIn;
    strb.remap       = quarterMode ^ modeQ;
    strb.nextQuarter = quarterMode;
    strb.curQuarter  = modeQ;
  end

  // R6
  no_double_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> !strb.advance);
endmodule

// File: rtl/stepSeqDatapath.sv
module stepSeqDatapath
  import stepSeqPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStrobe_t                       strb,
  output logic [NUM_WIND-1:0]              phaseOut,
  output logic [NUM_WIND-1:0][CODE_W-1:0]  codeOut
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] baseIdx;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] angle;

  function automatic logic [CODE_W-1:0] ampCode(input logic [IDX_W-2:0] pos);
    case (pos)
      3'd0, 3'd1, 3'd7: ampCode = 2'b00;
      3'd2, 3'd6:       ampCode = 2'b01;
      3'd3, 3'd5:       ampCode = 2'b10;
      default:          ampCode = 2'b11;
    endcase
  endfunction

  always_comb begin
    baseIdx = idx;
    if (strb.remap)
      baseIdx = strb.nextQuarter ? {idx[IDX_W-2:0], 1'b0} : {1'b0, idx[IDX_W-1:1]};
    nextIdx = baseIdx;
    if (strb.advance)
      nextIdx = strb.up ? baseIdx + 1'b1 : baseIdx - 1'b1;
    if (!strb.nextQuarter)
      nextIdx[IDX_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idx <= '0;
    else       idx <= nextIdx;
  end

  assign angle = strb.curQuarter ? idx : {idx[IDX_W-2:0], 1'b0};

  for (genvar w = 0; w < NUM_WIND; w++) begin : gWind
    localparam logic [IDX_W-1:0] OFFS = IDX_W'(QUARTER_LEN - QUAD * w);
    logic [IDX_W-1:0] windAngle;
    logic [IDX_W-1:0] phaseAngle;
    logic             heldPhase;
    logic             zeroAmp;

    assign windAngle  = angle + OFFS;
    assign phaseAngle = windAngle + IDX_W'(QUAD);
    assign codeOut[w] = ampCode(windAngle[IDX_W-2:0]);
    assign zeroAmp    = &codeOut[w];
    assign phaseOut[w] = zeroAmp ? heldPhase : phaseAngle[IDX_W-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) heldPhase <= 1'b0;
      else       heldPhase <= phaseOut[w];
    end

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      zeroAmp |-> $stable(phaseOut[w]));
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.remap) |=> $stable(idx));
  // R7
  quarter_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.up && !strb.remap && strb.curQuarter && idx == 4'd15) |=> idx == 4'd0);
  // R7
  half_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.up && !strb.remap && !strb.curQuarter && idx == 4'd0) |=> idx == 4'd7);
  // R8
  remap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.remap && strb.nextQuarter && !strb.advance) |=> idx == {$past(idx[IDX_W-2:0]), 1'b0});
  // R3
  half_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.curQuarter |-> !idx[IDX_W-1]);
endmodule

// File: rtl/stepSeqGen.sv
module stepSeqGen
  import stepSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic       quarterMode,
  output logic       phaseA,
  output logic [1:0] curSelA,
  output logic       phaseB,
  output logic [1:0] curSelB
);
  seqStrobe_t                      strb;
  logic [NUM_WIND-1:0]             phaseOut;
  logic [NUM_WIND-1:0][CODE_W-1:0] codeOut;

  stepSeqControl uCtrl (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn),
    .quarterMode(quarterMode), .strb(strb)
  );

  stepSeqDatapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .phaseOut(phaseOut), .codeOut(codeOut)
  );

  assign phaseA  = phaseOut[0];
  assign curSelA = codeOut[0];
  assign phaseB  = phaseOut[1];
  assign curSelB = codeOut[1];
endmodule

// File: tb/tb_stepSeqGen.sv
module tb_stepSeqGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepIn = 1'b1;
  logic dirIn = 1'b1;
  logic quarterMode = 1'b0;
  logic phaseA, phaseB;
  logic [1:0] curSelA, curSelB;

  always #2.5 clk = ~clk; // 200 MHz

  stepSeqGen dut (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn),
    .quarterMode(quarterMode), .phaseA(phaseA), .curSelA(curSelA),
    .phaseB(phaseB), .curSelB(curSelB)
  );

  // Tables written straight from the requirements (code 0=full..3=off, phase -1 = keep)
  int qA[16]  = '{0,0,1,2,3,2,1,0,0,0,1,2,3,2,1,0};
  int qAp[16] = '{0,0,0,0,-1,1,1,1,1,1,1,1,-1,0,0,0};
  int qB[16]  = '{3,2,1,0,0,0,1,2,3,2,1,0,0,0,1,2};
  int qBp[16] = '{-1,0,0,0,0,0,0,0,-1,1,1,1,1,1,1,1};
  int hA[8]   = '{0,1,3,1,0,1,3,1};
  int hAp[8]  = '{0,0,-1,1,1,1,-1,0};
  int hB[8]   = '{3,1,0,1,3,1,0,1};
  int hBp[8]  = '{-1,0,0,0,-1,1,1,1};

  int refIdx = 0;
  int refMode = 0;
  int refStepPrev = 1;
  int holdA = 0, holdB = 0;
  int compared = 0, mismatched = 0, cycles = 0;
  bit running = 1'b0;
  string tag = "R1";

  function automatic int codeA(int m, int i); return m ? qA[i] : hA[i]; endfunction
  function automatic int codeB(int m, int i); return m ? qB[i] : hB[i]; endfunction
  function automatic int phA(int m, int i);   return m ? qAp[i] : hAp[i]; endfunction
  function automatic int phB(int m, int i);   return m ? qBp[i] : hBp[i]; endfunction

  // Reference model
  always @(posedge clk) begin
    if (!rstN) begin
      refIdx = 0; refMode = 0; refStepPrev = 1; holdA = 0; holdB = 0;
    end else begin
      int len;
      if (int'(quarterMode) != refMode)
        refIdx = quarterMode ? refIdx * 2 : refIdx / 2;
      len = quarterMode ? 16 : 8;
      if (stepIn && refStepPrev == 0)
        refIdx = dirIn ? (refIdx + 1) % len : (refIdx + len - 1) % len;
      refMode = int'(quarterMode);
      refStepPrev = int'(stepIn);
      if (codeA(refMode, refIdx) != 3) holdA = phA(refMode, refIdx);
      if (codeB(refMode, refIdx) != 3) holdB = phB(refMode, refIdx);
    end
  end

  // Comparison on every falling edge
  always @(negedge clk) begin
    if (running) begin
      int eA, eB;
      eA = codeA(refMode, refIdx);
      eB = codeB(refMode, refIdx);
      compared++;
      if (int'(curSelA) != eA || int'(curSelB) != eB ||
          int'(phaseA) != holdA || int'(phaseB) != holdB) begin
        mismatched++;
        $display("FAIL %s state %0d mode %0d: got A=%0d/%b B=%0d/%b expected A=%0d/%0d B=%0d/%0d",
                 tag, refIdx, refMode, phaseA, curSelA, phaseB, curSelB,
                 holdA, eA, holdB, eB);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); stepIn = 1'b1;
      @(negedge clk); stepIn = 1'b0;
    end
  endtask

  initial begin
    running = 1'b1;
    tag = "R1";                       // reset state, step held high
    idle(4);
    tag = "R9";                       // release reset with step high
    rstN = 1'b1;
    idle(4);
    stepIn = 1'b0;
    idle(2);
    tag = "R3 R2 R5 R7 up";           // half-step forward, wraps 7->0
    dirIn = 1'b1; pulse(11);
    tag = "R3 R5 R7 down";            // half-step reverse, wraps 0->7
    dirIn = 1'b0; pulse(13);
    tag = "R6 held";                  // one step, step kept high
    @(negedge clk); stepIn = 1'b1; idle(6); stepIn = 1'b0; idle(2);
    tag = "R8 to quarter";            // half index -> 2k
    @(negedge clk); quarterMode = 1'b1; idle(3);
    tag = "R4 R2 R5 R7 up";
    dirIn = 1'b1; pulse(19);
    tag = "R8 to half odd";           // quarter odd index -> floor(k/2)
    @(negedge clk); quarterMode = 1'b0; idle(3);
    tag = "R8 to quarter with step";  // remap then step in new mode
    @(negedge clk); quarterMode = 1'b1; stepIn = 1'b1;
    @(negedge clk); stepIn = 1'b0; idle(2);
    tag = "R4 R5 R7 down";
    dirIn = 1'b0; pulse(21);
    tag = "R8 to half with step down";
    @(negedge clk); quarterMode = 1'b0; stepIn = 1'b1;
    @(negedge clk); stepIn = 1'b0; idle(2);
    tag = "R3 R7 down wrap";
    pulse(9);
    tag = "R1 reset again";
    @(negedge clk); rstN = 1'b0; stepIn = 1'b1; idle(3);
    tag = "R9 second release";
    rstN = 1'b1; idle(3); stepIn = 1'b0;
    tag = "R6 after reset";
    dirIn = 1'b1; pulse(2);
    idle(2);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule